// File: doc/BRIEF.md
# Two-Stage Early-Warning Watchdog

This block guards a host processor that must strobe a kick input at regular intervals. If the host misses that deadline, the block does not reset the system straight away. It first raises an interrupt-style warning. This gives software a short window to store diagnostic data.

A second, independent grace timer starts together with the warning. When that timer runs out, the block drives a hard reset for the whole system, which is held for a minimum number of cycles. Nothing the host does during the grace window can prevent or delay this reset.

The block also keeps a saturating count of the resets it has caused. Software can read it to spot a system that resets silently and often. The count is cleared only by power-on reset. Enable is sticky: once it has been seen high, only a power-on reset can turn the watchdog off again. A debug session therefore cannot leave the watchdog switched off by accident.

Top module: `ew_watchdog`

## Requirements
- R1: While `por_n` is low, and directly after it rises, `warn_irq_o` and `sys_rst_o` are 0 and `rst_count_o` is 0.
- R2: Until `enable_i` has been sampled high at a rising clock edge, both outputs stay 0 whatever `kick_i` does.
- R3: After `enable_i` has been sampled high once, driving it low again has no effect on timing or outputs until the next power-on reset.
- R4: When armed, a kick strobe reloads the primary timer. Kicks spaced no more than TIMEOUT_CYC cycles apart keep `warn_irq_o` low indefinitely, including a kick in the last cycle before expiry.
- R5: When armed, `warn_irq_o` rises after exactly TIMEOUT_CYC consecutive clock cycles with no kick, counted from the last kick, from arming, or from reset release.
- R6: `warn_irq_o` stays high for exactly GRACE_CYC cycles, and `sys_rst_o` rises in the cycle it falls. Kicks during this window are ignored.
- R7: `sys_rst_o` stays high for exactly HOLD_CYC cycles. `warn_irq_o` and `sys_rst_o` are never high together.
- R8: After `sys_rst_o` releases, the block is armed again with its timers cleared, so with no kicks the next warning follows after TIMEOUT_CYC cycles.
- R9: `rst_count_o` increases by one in the same cycle that `sys_rst_o` rises, and is otherwise stable.
- R10: `rst_count_o` saturates at its all-ones value. The watchdog's own reset never clears it; only `por_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| kick_i | input | 1 | Keep-alive strobe from the host, one cycle per kick |
| enable_i | input | 1 | Arms the watchdog; latched, cannot be withdrawn |
| warn_irq_o | output | 1 | Early-warning interrupt, high during the grace window |
| sys_rst_o | output | 1 | Hard system reset, active high, held HOLD_CYC cycles |
| rst_count_o | output | CNT_W | Saturating number of watchdog resets since power-on |

## Verification
The hardest state to reach is a saturated reset count, and the model has to stay aligned with it. Getting there takes many complete timeout, grace and hold sequences without an intervening power-on reset. A directed loop therefore starves the kick input through more sequences than the counter width allows, and then checks that a power-on reset alone clears the count. A second hard case is a kick that lands in the very last cycle of the timeout. This is driven directly, and random segments with different kick densities add near-expiry kicks and kicks inside the grace window. A cycle-level model in the bench predicts every output in every cycle.

// File: rtl/ew_watchdog_pkg.sv
package ew_watchdog_pkg;
  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_ARMED = 2'd1,
    WD_WARN  = 2'd2,
    WD_HOLD  = 2'd3
  } wd_state_e;
endpackage

// File: rtl/ew_sticky_enable.sv
module ew_sticky_enable (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  output logic on_o
);
  // Only power-on reset clears it: software may set but never clear.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) on_o <= 1'b0;
    else if (set_i) on_o <= 1'b1;
  end
endmodule

// File: rtl/ew_interval_timer.sv
module ew_interval_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic run_i,
  input  logic clr_i,
  output logic done_o
);
  generate
    if (LIMIT <= 1) begin : g_single
      // Expires in the first running cycle; no storage needed.
      assign done_o = run_i && !clr_i;
    end else begin : g_count
      localparam int W = $clog2(LIMIT);
      localparam logic [W-1:0] LAST = W'(LIMIT - 1);
      logic [W-1:0] cnt_q;

      assign done_o = run_i && !clr_i && (cnt_q == LAST);

      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else if (!run_i || clr_i || done_o) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/ew_sat_counter.sv
module ew_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] value_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) value_o <= '0;
    else if (inc_i && (value_o != TOP)) value_o <= value_o + 1'b1;
  end
endmodule

// File: rtl/ew_watchdog.sv
module ew_watchdog
  import ew_watchdog_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000000,
  parameter int GRACE_CYC   = 50000,
  parameter int HOLD_CYC    = 64,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             kick_i,
  input  logic             enable_i,
  output logic             warn_irq_o,
  output logic             sys_rst_o,
  output logic [CNT_W-1:0] rst_count_o
);
  wd_state_e state_q, state_d;
  logic      en_on;
  logic      prim_done, grace_done, hold_done;

  ew_sticky_enable u_en (
    .clk   (clk),
    .por_n (por_n),
    .set_i (enable_i),
    .on_o  (en_on)
  );

  // Primary timeout: reloaded by kicks, runs only while armed.
  ew_interval_timer #(.LIMIT(TIMEOUT_CYC)) u_prim (
    .clk    (clk),
    .por_n  (por_n),
    .run_i  (state_q == WD_ARMED),
    .clr_i  (kick_i),
    .done_o (prim_done)
  );

  // Grace timer: has no clear input, so a kick cannot stop it.
  ew_interval_timer #(.LIMIT(GRACE_CYC)) u_grace (
    .clk    (clk),
    .por_n  (por_n),
    .run_i  (state_q == WD_WARN),
    .clr_i  (1'b0),
    .done_o (grace_done)
  );

  ew_interval_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk    (clk),
    .por_n  (por_n),
    .run_i  (state_q == WD_HOLD),
    .clr_i  (1'b0),
    .done_o (hold_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WD_IDLE:  if (en_on) state_d = WD_ARMED;
      WD_ARMED: if (prim_done) state_d = WD_WARN;
      WD_WARN:  if (grace_done) state_d = WD_HOLD;
      WD_HOLD:  if (hold_done) state_d = WD_ARMED;
      default:  state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= WD_IDLE;
    else state_q <= state_d;
  end

  ew_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .por_n   (por_n),
    .inc_i   ((state_q == WD_WARN) && grace_done),
    .value_o (rst_count_o)
  );

  assign warn_irq_o = (state_q == WD_WARN);
  assign sys_rst_o  = (state_q == WD_HOLD);
endmodule

// File: rtl/ew_watchdog_checker.sv
module ew_watchdog_checker #(
  parameter int GRACE_CYC = 8,
  parameter int HOLD_CYC  = 4,
  parameter int CNT_W     = 8
) (
  input logic             clk,
  input logic             por_n,
  input logic             kick_i,
  input logic             enable_i,
  input logic             warn_irq_o,
  input logic             sys_rst_o,
  input logic [CNT_W-1:0] rst_count_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic seen_en_q;
  int   warn_run_q, rst_run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      seen_en_q  <= 1'b0;
      warn_run_q <= 0;
      rst_run_q  <= 0;
    end else begin
      if (enable_i) seen_en_q <= 1'b1;
      warn_run_q <= warn_irq_o ? warn_run_q + 1 : 0;
      rst_run_q  <= sys_rst_o ? rst_run_q + 1 : 0;
    end
  end

  assert_idle_until_enabled_R2: assert property (@(posedge clk) disable iff (!por_n)
    !seen_en_q |-> (!warn_irq_o && !sys_rst_o));

  assert_exclusive_outputs_R7: assert property (@(posedge clk) disable iff (!por_n)
    !(warn_irq_o && sys_rst_o));

  assert_warn_then_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(warn_irq_o) |-> sys_rst_o);

  assert_kick_ignored_R6: assert property (@(posedge clk) disable iff (!por_n)
    (warn_irq_o && kick_i) |=> (warn_irq_o || sys_rst_o));

  assert_grace_width_R6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_o) |-> (warn_run_q == GRACE_CYC));

  assert_hold_width_R7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst_o) |-> (rst_run_q == HOLD_CYC));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_o) |-> ((rst_count_o == $past(rst_count_o) + CNT_W'(1)) ||
                          ((rst_count_o == CMAX) && ($past(rst_count_o) == CMAX))));

  assert_count_stable_R10: assert property (@(posedge clk) disable iff (!por_n)
    !$rose(sys_rst_o) |-> $stable(rst_count_o));
endmodule

bind ew_watchdog ew_watchdog_checker #(
  .GRACE_CYC (GRACE_CYC),
  .HOLD_CYC  (HOLD_CYC),
  .CNT_W     (CNT_W)
) u_checker (
  .clk         (clk),
  .por_n       (por_n),
  .kick_i      (kick_i),
  .enable_i    (enable_i),
  .warn_irq_o  (warn_irq_o),
  .sys_rst_o   (sys_rst_o),
  .rst_count_o (rst_count_o)
);

// File: tb/ew_watchdog_tb_top.sv
module ew_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T  = 16;
  localparam int G  = 8;
  localparam int H  = 4;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic kick = 1'b0;
  logic en = 1'b0;
  logic warn_o, rst_o;
  logic [CW-1:0] cnt_o;

  int checks = 0;
  int errors = 0;
  // reference model state: 0 idle, 1 armed, 2 warn, 3 hold
  int m_st = 0, m_c = 0, m_cnt = 0;
  bit m_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ew_watchdog #(.TIMEOUT_CYC(T), .GRACE_CYC(G), .HOLD_CYC(H), .CNT_W(CW)) dut_i (
    .clk(clk), .por_n(por_n), .kick_i(kick), .enable_i(en),
    .warn_irq_o(warn_o), .sys_rst_o(rst_o), .rst_count_o(cnt_o));

  function automatic int sat_inc(int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(bit k);
    if (!por_n) begin
      m_st = 0; m_c = 0; m_cnt = 0; m_en = 1'b0;
      return;
    end
    case (m_st)
      0: if (m_en) begin m_st = 1; m_c = 0; end
      1: if (k) m_c = 0;
         else if (m_c == T-1) begin m_st = 2; m_c = 0; end
         else m_c++;
      2: if (m_c == G-1) begin m_st = 3; m_c = 0; m_cnt = sat_inc(m_cnt); end
         else m_c++;
      default: if (m_c == H-1) begin m_st = 1; m_c = 0; end
               else m_c++;
    endcase
    if (en) m_en = 1'b1;
  endtask

  task automatic compare();
    check(warn_o == (m_st == 2), "R5/R6 warn", int'(warn_o), int'(m_st == 2));
    check(rst_o == (m_st == 3), "R7 reset", int'(rst_o), int'(m_st == 3));
    check(int'(cnt_o) == m_cnt, "R9 count", int'(cnt_o), m_cnt);
  endtask

  // Called at a falling edge: drive, take the rising edge, sample at the next falling edge.
  task automatic cycle(bit k, bit e);
    kick = k; en = e;
    @(posedge clk);
    #1 model_step(k);
    @(negedge clk);
    compare();
  endtask

  task automatic por_pulse();
    por_n = 1'b0;
    cycle(0, 0);
    cycle(0, 0);
    por_n = 1'b1;
    cycle(0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    int unused_seed;
    unused_seed = $urandom(20190101);
    @(negedge clk);
    por_pulse();
    check(!warn_o && !rst_o && cnt_o == 0, "R1 reset state",
          int'({warn_o, rst_o}) + int'(cnt_o), 0);

    // R2: not enabled, random kicks, nothing happens
    seen = 0;
    for (int i = 0; i < 5*T; i++) begin
      cycle(1'($urandom % 2), 0);
      if (warn_o || rst_o) seen = 1;
    end
    check(!seen, "R2 idle while disabled", int'(seen), 0);

    // R3: one-cycle enable, then withdrawn; R4: kicks every T cycles keep it quiet
    cycle(0, 1);
    seen = 0;
    for (int r = 0; r < 8; r++) begin
      cycle(1, 0);
      for (int i = 0; i < T-1; i++) begin
        cycle(0, 0);
        if (warn_o || rst_o) seen = 1;
      end
    end
    check(!seen, "R4 last-cycle kicks hold off warning", int'(seen), 0);

    // R5 and R3: timeout after kick, with enable low
    cycle(1, 0);
    n = 0;
    while (!warn_o && n < 1000) begin cycle(0, 0); n++; end
    check(n == T, "R5 timeout length (R3 enable withdrawn)", n, T);

    // R6: kicks during grace ignored
    n = 0;
    while (warn_o && n < 1000) begin n++; cycle(1, 0); end
    check(n == G, "R6 grace length", n, G);
    check(rst_o == 1'b1, "R6 reset follows warning", int'(rst_o), 1);
    check(int'(cnt_o) == 1, "R9 count after first reset", int'(cnt_o), 1);

    // R7
    n = 0; seen = 0;
    while (rst_o && n < 1000) begin
      n++;
      if (warn_o) seen = 1;
      cycle(0, 0);
    end
    check(n == H, "R7 hold length", n, H);
    check(!seen, "R7 outputs exclusive", int'(seen), 0);

    // R8
    n = 0;
    while (!warn_o && n < 1000) begin cycle(0, 0); n++; end
    check(n == T, "R8 rearmed timeout", n, T);

    // R10: run to saturation without POR
    for (int r = 0; r < CMAX + 3; r++) begin
      n = 0;
      while (!rst_o && n < 1000) begin cycle(0, 0); n++; end
      while (rst_o && n < 2000) begin cycle(0, 0); n++; end
    end
    check(int'(cnt_o) == CMAX, "R10 saturated count", int'(cnt_o), CMAX);
    por_pulse();
    check(int'(cnt_o) == 0, "R10 POR clears count", int'(cnt_o), 0);
    check(!warn_o && !rst_o, "R1 idle after POR", int'({warn_o, rst_o}), 0);

    // Random segments with varying kick density (R4, R5, R6 mixed)
    for (int s = 0; s < 24; s++) begin
      int pct;
      pct = (s % 3 == 0) ? 60 : ((s % 3 == 1) ? 12 : 3);
      for (int i = 0; i < 150; i++) begin
        cycle(1'(($urandom % 100) < pct), 1'(($urandom % 8) == 0));
      end
      if (($urandom % 6) == 0) por_pulse();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule